// File: doc/BRIEF.md
# Tag-Store Invalidation Sequencer

This block clears every entry of a small tag store or CAM when software asks for it. Software writes a one to a start bit. The sequencer then does the following:

- It accepts the request and clears its done flag.
- It drops the start bit again by itself.
- It waits a programmable number of cycles.
- It walks the entries in ascending order and sends one invalidate command per cycle whenever the target is ready.
- It counts target acknowledgements separately from issued commands.
- It waits the same programmable interval again and then raises done.

For debug, the block exposes its phase as a small state code, an abort flag and a ready-for-reset indication. If acknowledgements stall for longer than a fixed timeout, the sequence stops with the abort flag set and done left clear. The command port to the tag store is a plain valid/ready pair with an entry index, plus a one-cycle acknowledge pulse per completed entry.

Top module: `inval_seq_top`

## Requirements
- R1: A start write while the block is idle sets the start bit on the next clock edge. The hardware clears the bit on the following edge, so the bit is never seen high at the same time as done.
- R2: An accepted start clears done and abort. Done is set only when a full sequence completes, and it stays set until the next accepted start.
- R3: Invalidate commands carry the indices 0 up to NUM_ENTRIES-1, in ascending order, each exactly once. One command completes per cycle in which cmd_valid and cmd_ready are both high. While cmd_ready is low, cmd_valid stays high and cmd_idx holds its value. No command is driven while idle.
- R4: The issued counter counts command handshakes. The completed counter counts acknowledge pulses only while acknowledgements are outstanding, so it never exceeds the issued counter. Acknowledge pulses received while idle, or with nothing outstanding, change nothing.
- R5: The state code reads 0 for idle, 1 for the leading wait, 2 for issuing, 3 for draining acknowledgements and 4 for the trailing wait.
- R6: The leading wait and the trailing wait each last wait_cfg+1 cycles.
- R7: If TIMEOUT consecutive cycles pass with acknowledgements outstanding and none arriving, the abort flag is set, the state returns to 0 and done stays 0.
- R8: A start write that arrives while a sequence is running is ignored. The start bit stays 0, and the running sequence still ends with both counters at NUM_ENTRIES.
- R9: After reset, all outputs are 0 except rst_rdy. rst_rdy is 1 exactly while the block is idle with no start pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | One-cycle write of 1 to the start bit |
| wait_cfg | input | WAIT_W | Wait interval setting, held at its reset value by software |
| cmd_ready | input | 1 | Tag store can take an invalidate |
| ack_valid | input | 1 | One entry finished its invalidate |
| cmd_valid | output | 1 | Invalidate command valid |
| cmd_idx | output | IDX_W | Entry index of the command |
| issued_cnt | output | CNT_W | Entries with an invalidate issued |
| done_cnt | output | CNT_W | Entries acknowledged as complete |
| start_bit | output | 1 | Start bit readback, self-clearing |
| done | output | 1 | Sequence completed |
| abort_flag | output | 1 | Sequence stopped by timeout |
| rst_rdy | output | 1 | Idle with no pending start; target may be reset |
| fsm_state | output | 3 | Current phase code |

## Verification
The bench builds the block with NUM_ENTRIES = 24 and TIMEOUT = 16. With a short walk and a short timeout, full sequences, ready stalls, spurious acknowledgements, start writes while busy and an acknowledge starvation that ends in abort all fit into a few hundred cycles each. The counters are then 5 bits wide, so a completed walk brings them close to the top of their range. Random runs vary the wait setting from 0 to 7, which covers the zero-length wait corner.

// File: rtl/inval_pkg.sv
package inval_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ISSUE = 3'd2,
    ST_DRAIN = 3'd3,
    ST_POST  = 3'd4
  } inval_state_e;
endpackage

// File: rtl/inval_ctrl_regs.sv
module inval_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic idle,
  input  logic launch,
  input  logic finish,
  input  logic abort_evt,
  output logic start_q,
  output logic done_q,
  output logic abort_q,
  output logic accept
);
  logic start_d, done_d, abort_d;
  logic start_en, done_en, abort_en;

  assign accept = start_wr & idle & ~start_q;

  always_comb begin
    start_en = accept | launch;
    start_d  = accept;
    done_en  = accept | finish;
    done_d   = ~accept & finish;
    abort_en = accept | abort_evt;
    abort_d  = ~accept & abort_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (start_en) start_q <= start_d;
      if (done_en)  done_q  <= done_d;
      if (abort_en) abort_q <= abort_d;
    end
  end

  AST_START_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n) start_q |=> !start_q); // R1
  AST_DONE_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(start_q && done_q)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (start_wr && !idle) |=> !start_q); // R8
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) abort_q |-> !done_q); // R7
endmodule

// File: rtl/inval_fsm.sv
module inval_fsm
  import inval_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_q,
  input  logic              all_issued,
  input  logic              all_done,
  input  logic              timeout_hit,
  input  logic [WAIT_W-1:0] wait_cfg,
  output inval_state_e      state_o,
  output logic              launch,
  output logic              finish,
  output logic              abort_evt
);
  inval_state_e      state_q, state_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic              wcnt_en;

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    wcnt_en   = 1'b0;
    launch    = 1'b0;
    finish    = 1'b0;
    abort_evt = 1'b0;
    case (state_q)
      ST_IDLE: if (start_q) begin
        state_d = ST_PRE;
        launch  = 1'b1;
        wcnt_en = 1'b1;
        wcnt_d  = wait_cfg;
      end
      ST_PRE: begin
        wcnt_en = 1'b1;
        if (wcnt_q == '0) state_d = ST_ISSUE;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      ST_ISSUE: begin
        if (timeout_hit) begin
          state_d   = ST_IDLE;
          abort_evt = 1'b1;
        end else if (all_issued) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (timeout_hit) begin
          state_d   = ST_IDLE;
          abort_evt = 1'b1;
        end else if (all_done) begin
          state_d = ST_POST;
          wcnt_en = 1'b1;
          wcnt_d  = wait_cfg;
        end
      end
      ST_POST: begin
        wcnt_en = 1'b1;
        if (wcnt_q == '0) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
    end
  end

  assign state_o = state_q;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) state_q inside {ST_IDLE, ST_PRE, ST_ISSUE, ST_DRAIN, ST_POST}); // R5
  AST_FINISH_FROM_POST: assert property (@(posedge clk) disable iff (!rst_n) finish |=> state_q == ST_IDLE); // R2
endmodule

// File: rtl/inval_walker.sv
module inval_walker #(
  parameter int NUM_ENTRIES = 384,
  parameter int TIMEOUT     = 64,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1),
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int TMO_W = $clog2(TIMEOUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             issue_en,
  input  logic             track_en,
  input  logic             cmd_ready,
  input  logic             ack_valid,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [CNT_W-1:0] issued_cnt,
  output logic [CNT_W-1:0] done_cnt,
  output logic             all_issued,
  output logic             all_done,
  output logic             timeout_hit
);
  logic [CNT_W-1:0] iss_q, iss_d, cmp_q, cmp_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             iss_en, cmp_en, hs, outstanding, ack_take;

  assign all_issued  = (iss_q == CNT_W'(NUM_ENTRIES));
  assign all_done    = (cmp_q == CNT_W'(NUM_ENTRIES));
  assign cmd_valid   = issue_en & ~all_issued;
  assign hs          = cmd_valid & cmd_ready;
  assign outstanding = (cmp_q != iss_q);
  assign ack_take    = track_en & ack_valid & outstanding;
  assign timeout_hit = track_en & outstanding & ~ack_take & (tmo_q == TMO_W'(TIMEOUT - 1));

  always_comb begin
    iss_en = clear | hs;
    iss_d  = clear ? '0 : iss_q + 1'b1;
    cmp_en = clear | ack_take;
    cmp_d  = clear ? '0 : cmp_q + 1'b1;
    if (clear || !track_en || ack_take || !outstanding) tmo_d = '0;
    else                                                tmo_d = tmo_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= '0;
      cmp_q <= '0;
      tmo_q <= '0;
    end else begin
      if (iss_en) iss_q <= iss_d;
      if (cmp_en) cmp_q <= cmp_d;
      tmo_q <= tmo_d;
    end
  end

  assign cmd_idx    = iss_q[IDX_W-1:0];
  assign issued_cnt = iss_q;
  assign done_cnt   = cmp_q;

  AST_ACK_LE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) cmp_q <= iss_q); // R4
  AST_ISSUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) iss_q <= CNT_W'(NUM_ENTRIES)); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && !cmd_ready) |=> $stable(cmd_idx)); // R3
endmodule

// File: rtl/inval_seq_top.sv
module inval_seq_top
  import inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 384,
  parameter int TIMEOUT     = 64,
  parameter int WAIT_W      = 8,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1),
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              cmd_ready,
  input  logic              ack_valid,
  output logic              cmd_valid,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic [CNT_W-1:0]  issued_cnt,
  output logic [CNT_W-1:0]  done_cnt,
  output logic              start_bit,
  output logic              done,
  output logic              abort_flag,
  output logic              rst_rdy,
  output logic [2:0]        fsm_state
);
  inval_state_e st;
  logic idle, launch, finish, abort_evt, accept;
  logic all_issued, all_done, timeout_hit;

  assign idle = (st == ST_IDLE);

  inval_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .idle(idle),
    .launch(launch), .finish(finish), .abort_evt(abort_evt),
    .start_q(start_bit), .done_q(done), .abort_q(abort_flag), .accept(accept)
  );

  inval_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_q(start_bit), .all_issued(all_issued),
    .all_done(all_done), .timeout_hit(timeout_hit), .wait_cfg(wait_cfg),
    .state_o(st), .launch(launch), .finish(finish), .abort_evt(abort_evt)
  );

  inval_walker #(.NUM_ENTRIES(NUM_ENTRIES), .TIMEOUT(TIMEOUT)) u_walk (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .issue_en(st == ST_ISSUE), .track_en((st == ST_ISSUE) || (st == ST_DRAIN)),
    .cmd_ready(cmd_ready), .ack_valid(ack_valid),
    .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .issued_cnt(issued_cnt),
    .done_cnt(done_cnt), .all_issued(all_issued), .all_done(all_done),
    .timeout_hit(timeout_hit)
  );

  assign rst_rdy   = idle & ~start_bit;
  assign fsm_state = st;

  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !cmd_valid); // R3
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(abort_flag) |-> idle); // R7
endmodule

// File: tb/inval_seq_top_tb.sv
module inval_seq_top_tb;
  localparam int NUM = 24;
  localparam int TMO = 16;
  localparam int CW  = $clog2(NUM + 1);
  localparam int IW  = $clog2(NUM);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_wr = 1'b0;
  logic [7:0] wait_cfg = 8'd0;
  logic cmd_ready = 1'b0;
  logic ack_valid = 1'b0;
  logic cmd_valid, start_bit, done, abort_flag, rst_rdy;
  logic [IW-1:0] cmd_idx;
  logic [CW-1:0] issued_cnt, done_cnt;
  logic [2:0] fsm_state;

  int n_chk = 0;
  int n_fail = 0;
  int ready_mode = 0;   // 0 always, 1 random, 2 held low
  int ack_mode = 1;     // 0 none, 1 random when outstanding, 2 every cycle
  int pend = 0;
  int exp_idx = 0;
  int ord_err = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  inval_seq_top #(.NUM_ENTRIES(NUM), .TIMEOUT(TMO), .WAIT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .wait_cfg(wait_cfg),
    .cmd_ready(cmd_ready), .ack_valid(ack_valid), .cmd_valid(cmd_valid),
    .cmd_idx(cmd_idx), .issued_cnt(issued_cnt), .done_cnt(done_cnt),
    .start_bit(start_bit), .done(done), .abort_flag(abort_flag),
    .rst_rdy(rst_rdy), .fsm_state(fsm_state)
  );

  // Target model: drives inputs away from the active edge
  always @(negedge clk) begin
    case (ready_mode)
      0: cmd_ready = 1'b1;
      1: cmd_ready = ($urandom_range(0, 2) != 0);
      default: cmd_ready = 1'b0;
    endcase
    case (ack_mode)
      1: ack_valid = (pend > 0) && ($urandom_range(0, 3) != 0);
      2: ack_valid = 1'b1;
      default: ack_valid = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    pend <= pend + ((cmd_valid && cmd_ready) ? 1 : 0) - ((ack_valid && pend > 0) ? 1 : 0);
    if (start_bit) exp_idx <= 0;
    else if (cmd_valid && cmd_ready) begin
      if (int'(cmd_idx) != exp_idx) ord_err <= ord_err + 1;
      exp_idx <= exp_idx + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_wait_len(input int w);
    return w + 1;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Starts a sequence and follows it to idle
  task automatic run_seq(input int w, input bit poke, output int pre, output int post);
    int cyc;
    pre = 0; post = 0; cyc = 0;
    @(negedge clk);
    wait_cfg = 8'(w);
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    chk(start_bit == 1'b1, "R1 start set", start_bit, 1);
    chk(done == 1'b0, "R2 done cleared", done, 0);
    chk(rst_rdy == 1'b0, "R9 rst_rdy busy", rst_rdy, 0);
    @(negedge clk);
    chk(start_bit == 1'b0, "R1 start self-clear", start_bit, 0);
    chk(fsm_state == 3'd1, "R5 pre-wait code", fsm_state, 1);
    if (fsm_state == 3'd1) pre++;
    while (fsm_state != 3'd0 && cyc < 5000) begin
      if (poke && cyc == 2) start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
      if (poke && cyc == 2) chk(start_bit == 1'b0, "R8 busy start ignored", start_bit, 0);
      if (fsm_state == 3'd1) pre++;
      if (fsm_state == 3'd4) post++;
      cyc++;
    end
    chk(cyc < 5000, "R2 sequence ends", cyc, 0);
  endtask

  initial begin
    int pre, post, w, seen_idx, seen_iss;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(fsm_state == 3'd0, "R9 reset state", fsm_state, 0);
    chk(done == 1'b0 && abort_flag == 1'b0 && start_bit == 1'b0, "R9 reset flags", {done, abort_flag, start_bit}, 0);
    chk(rst_rdy == 1'b1, "R9 reset rst_rdy", rst_rdy, 1);
    chk(issued_cnt == 0 && done_cnt == 0 && cmd_valid == 0, "R9 reset counters", issued_cnt, 0);

    // Directed full walk
    ready_mode = 0; ack_mode = 1;
    run_seq(3, 1'b0, pre, post);
    chk(pre == exp_wait_len(3), "R6 pre-wait length", pre, exp_wait_len(3));
    chk(post == exp_wait_len(3), "R6 post-wait length", post, exp_wait_len(3));
    chk(done == 1'b1 && abort_flag == 1'b0, "R2 done after walk", {done, abort_flag}, 2);
    chk(issued_cnt == NUM, "R4 issued count", issued_cnt, NUM);
    chk(done_cnt == NUM, "R4 completed count", done_cnt, NUM);
    chk(ord_err == 0, "R3 index order", ord_err, 0);
    chk(rst_rdy == 1'b1, "R9 rst_rdy idle", rst_rdy, 1);

    // Spurious acks while idle
    ack_mode = 2;
    repeat (5) @(negedge clk);
    ack_mode = 1;
    chk(done_cnt == NUM, "R4 idle acks ignored", done_cnt, NUM);

    // Random runs, one with a start write while busy
    for (int k = 0; k < 5; k++) begin
      w = $urandom_range(0, 7);
      ready_mode = 1;
      run_seq(w, k == 1, pre, post);
      chk(pre == exp_wait_len(w) && post == exp_wait_len(w), "R6 random wait", pre, exp_wait_len(w));
      chk(done == 1'b1 && issued_cnt == NUM && done_cnt == NUM, "R8 R4 random run counts", done_cnt, NUM);
      chk(ord_err == 0, "R3 random order", ord_err, 0);
    end

    // Acks every cycle beyond what is outstanding
    ready_mode = 1; ack_mode = 2;
    run_seq(0, 1'b0, pre, post);
    chk(done_cnt == NUM && issued_cnt == NUM, "R4 excess acks", done_cnt, NUM);
    ack_mode = 1;

    // Ready stall during issue
    ready_mode = 2;
    @(negedge clk);
    wait_cfg = 8'd1; start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    for (int i = 0; i < 100 && fsm_state != 3'd2; i++) @(negedge clk);
    seen_idx = int'(cmd_idx); seen_iss = int'(issued_cnt);
    repeat (5) @(negedge clk);
    chk(cmd_valid == 1'b1, "R3 valid held in stall", cmd_valid, 1);
    chk(int'(cmd_idx) == seen_idx && int'(issued_cnt) == seen_iss, "R3 index held in stall", cmd_idx, seen_idx);
    chk(fsm_state == 3'd2, "R5 issue code", fsm_state, 2);
    ready_mode = 0;
    for (int i = 0; i < 1000 && fsm_state != 3'd0; i++) @(negedge clk);
    chk(done == 1'b1 && done_cnt == NUM, "R2 done after stall", done_cnt, NUM);

    // Acknowledge starvation
    ack_mode = 0;
    run_seq(2, 1'b0, pre, post);
    chk(abort_flag == 1'b1, "R7 abort set", abort_flag, 1);
    chk(done == 1'b0, "R7 done stays clear", done, 0);
    chk(fsm_state == 3'd0 && done_cnt == 0 && issued_cnt != 0, "R7 idle after abort", fsm_state, 0);

    // Recovery run clears abort
    ack_mode = 1;
    run_seq(1, 1'b0, pre, post);
    chk(abort_flag == 1'b0 && done == 1'b1, "R2 abort cleared by start", abort_flag, 0);
    chk(done_cnt == NUM, "R4 recovery count", done_cnt, NUM);

    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    finish_run();
  end
endmodule